// File: doc/BRIEF.md
# System Clock Enable Divider Bank

This block turns one fast root clock into eight periodic clock-enable pulses. Each pulse is one root-clock cycle wide, so downstream logic can run at the divided rate without a second clock net. Five channels use ratios that are fixed at build time. Three channels take ratios written through a small register port: two general channels and one slow system channel. The slow channel has a stricter range than the other two.

A cross-channel rule protects the system: the slow channel must never run faster than either general programmable channel. The block compares the programmed ratios on every cycle. A breach sets a sticky error flag, and software clears the flag by writing 1 to it. A new ratio is held as pending and takes effect only after the divider's next terminal pulse. This way no period is ever cut short. All counters start from zero together when reset is released.

Top module: `sysclk_div_bank`

## Requirements
- R1: While reset is asserted, `cfg_err` is 0 and every counter sits at zero. With the default ratios this means `clk_en` reads 8'h01. After reset is released, a channel with ratio N first pulses N-1 cycles later and then once every N cycles.
- R2: The fixed channels divide as follows: `clk_en[2]` by 64, `clk_en[3]` by 6, `clk_en[5]` by 12, `clk_en[6]` by 3 and `clk_en[7]` by 6.
- R3: `clk_en[0]` (wr_sel 0) and `clk_en[1]` (wr_sel 1) accept ratios from 1 to 64. Their defaults are 1 and 3.
- R4: The slow channel `clk_en[4]` (wr_sel 2) defaults to ratio 64 and accepts any ratio from 24 to 80, including both end values.
- R5: A write with a ratio outside its channel's range is ignored, and the previous ratio stays in force.
- R6: A written ratio takes effect at the edge that follows the channel's next terminal pulse. The period in progress finishes at the old ratio.
- R7: For a ratio of 2 or more, the enable is high for exactly one cycle per period. A ratio of 1 holds the enable high.
- R8: If the slow ratio is smaller than either general programmable ratio, `cfg_err` rises two cycles after the write that causes the breach. It then stays high for as long as it is not cleared.
- R9: Writing wr_sel 3 with wr_data[0]=1 clears `cfg_err` on the next cycle, unless the breach still exists. Writing wr_data[0]=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0/1 general channels, 2 slow channel, 3 error clear |
| wr_data | input | RW (7) | Ratio value, or the clear bit in bit 0 |
| clk_en | output | 8 | One enable pulse per channel per period |
| cfg_err | output | 1 | Sticky cross-channel rule violation flag |

## Verification
On every cycle, the assertions check that:
- the stored ratios stay inside their legal ranges;
- rejected slow writes leave the ratio untouched;
- a breach raises the flag, and the flag holds until a clear;
- a clear with no breach drops the flag;
- the divide-by-3 and divide-by-6 fixed channels keep their pulse shape.

Only the bench scenarios can show the exact pulse trains after reset and the phase at which a new ratio takes over. The same applies to clearing while a breach persists, and to the range boundaries seen through the resulting pulse periods.

// File: rtl/sysclk_div_bank.sv
module sysclk_div_bank #(
  parameter int RW     = 7,
  parameter int A_DEF  = 1,
  parameter int B_DEF  = 3,
  parameter int S_DEF  = 64,
  parameter int P_MIN  = 1,
  parameter int P_MAX  = 64,
  parameter int S_MIN  = 24,
  parameter int S_MAX  = 80,
  parameter int DIV2   = 64,
  parameter int DIV3   = 6,
  parameter int DIV5   = 12,
  parameter int DIV6   = 3,
  parameter int DIV7   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [RW-1:0] wr_data,
  output logic [7:0]    clk_en,
  output logic          cfg_err
);
  localparam int NCH = 8;
  localparam logic [NCH-1:0] PROG = 8'b0001_0011;
  localparam int RATIO [NCH] = '{A_DEF, B_DEF, DIV2, DIV3, S_DEF, DIV5, DIV6, DIV7};
  localparam logic [RW-1:0] PMN = RW'(P_MIN);
  localparam logic [RW-1:0] PMX = RW'(P_MAX);
  localparam logic [RW-1:0] SMN = RW'(S_MIN);
  localparam logic [RW-1:0] SMX = RW'(S_MAX);

  logic [RW-1:0] pend_a, pend_b, pend_s;
  logic          p_ok, s_ok, viol, clr;

  assign p_ok = (wr_data >= PMN) && (wr_data <= PMX);
  assign s_ok = (wr_data >= SMN) && (wr_data <= SMX);
  assign viol = (pend_s < pend_a) || (pend_s < pend_b);
  assign clr  = wr_en && (wr_sel == 2'd3) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a <= RW'(A_DEF);
      pend_b <= RW'(B_DEF);
      pend_s <= RW'(S_DEF);
    end else if (wr_en) begin
      if (wr_sel == 2'd0 && p_ok) pend_a <= wr_data;
      if (wr_sel == 2'd1 && p_ok) pend_b <= wr_data;
      if (wr_sel == 2'd2 && s_ok) pend_s <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= (cfg_err && !clr) || viol;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [RW-1:0] cnt;
    logic [RW-1:0] cur;

    if (PROG[i]) begin : g_p
      logic [RW-1:0] nxt;
      assign nxt = (i == 0) ? pend_a : (i == 1) ? pend_b : pend_s;
      always_ff @(posedge clk) begin
        if (!rst_n)         cur <= RW'(RATIO[i]);
        else if (clk_en[i]) cur <= nxt;
      end
    end else begin : g_f
      assign cur = RW'(RATIO[i]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (clk_en[i]) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end

    assign clk_en[i] = (cnt == cur - 1'b1);
  end
endmodule

// File: rtl/sysclk_div_bank_chk.sv
module sysclk_div_bank_chk #(
  parameter int RW    = 7,
  parameter int P_MIN = 1,
  parameter int P_MAX = 64,
  parameter int S_MIN = 24,
  parameter int S_MAX = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [RW-1:0] wr_data,
  input logic [7:0]    clk_en,
  input logic          cfg_err,
  input logic [RW-1:0] pend_a,
  input logic [RW-1:0] pend_b,
  input logic [RW-1:0] pend_s
);
  localparam logic [RW-1:0] PMN = RW'(P_MIN);
  localparam logic [RW-1:0] PMX = RW'(P_MAX);
  localparam logic [RW-1:0] SMN = RW'(S_MIN);
  localparam logic [RW-1:0] SMX = RW'(S_MAX);

  // R4
  slow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_s >= SMN && pend_s <= SMX);

  // R3
  prog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_a >= PMN && pend_a <= PMX && pend_b >= PMN && pend_b <= PMX);

  // R5
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && (wr_data < SMN || wr_data > SMX) |=> $stable(pend_s));

  // R8
  viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_s < pend_a || pend_s < pend_b) |=> cfg_err);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !(wr_en && wr_sel == 2'd3 && wr_data[0]) |=> cfg_err);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd3 && wr_data[0] && pend_s >= pend_a && pend_s >= pend_b |=> !cfg_err);

  // R7
  div3_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[6] |=> !clk_en[6] ##1 !clk_en[6] ##1 clk_en[6]);

  // R2
  div6_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[3] |=> !clk_en[3]);
endmodule

bind sysclk_div_bank sysclk_div_bank_chk #(
  .RW(RW), .P_MIN(P_MIN), .P_MAX(P_MAX), .S_MIN(S_MIN), .S_MAX(S_MAX)
) u_chk (.*);

// File: tb/tb_sysclk_div_bank.sv
`timescale 1ns/1ps
module tb_sysclk_div_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [6:0] wr_data = 7'd0;
  logic [7:0] clk_en;
  logic       cfg_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int    ch;
    int    at;
    bit    val;
    string tag;
  } item_t;
  item_t q[$];

  sysclk_div_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clk_en(clk_en), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (running) cyc <= cyc + 1;

  // driver helpers: push expected items
  task automatic push(input int ch, input int at, input bit val, input string tag);
    item_t it;
    it.ch = ch; it.at = at; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_train(input int ch, input int from, input int upto,
                           input int first, input int period, input string tag);
    for (int c = from; c <= upto; c++)
      push(ch, c, (c >= first) && ((c - first) % period == 0), tag);
  endtask

  task automatic exp_err(input int from, input int upto, input bit val, input string tag);
    for (int c = from; c <= upto; c++) push(8, c, val, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input int data, input int at);
    while (cyc != at) @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 7'(data);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: pop items due this cycle and compare
  always @(negedge clk) begin
    if (running) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          bit act;
          act = (q[i].ch == 8) ? cfg_err : clk_en[q[i].ch];
          tests++;
          if (act !== q[i].val) begin
            fails++;
            $display("FAIL %s ch%0d cycle %0d: actual %0b expected %0b",
                     q[i].tag, q[i].ch, cyc, act, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (clk_en !== 8'h01 || cfg_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: actual clk_en=%h err=%b expected 01/0", clk_en, cfg_err);
    end

    // R1 R2 R3 R4 R7: default trains after reset
    exp_train(0, 0, 191, 0, 1, "R1");
    exp_train(1, 0, 191, 2, 3, "R3");
    exp_train(2, 0, 191, 63, 64, "R2");
    exp_train(3, 0, 191, 5, 6, "R2");
    exp_train(4, 0, 191, 63, 64, "R4");
    exp_train(5, 0, 191, 11, 12, "R2");
    exp_train(6, 0, 191, 2, 3, "R7");
    exp_train(7, 0, 191, 5, 6, "R2");
    exp_err(0, 191, 1'b0, "R1");
    rst_n = 1'b1;
    running = 1'b1;

    // R6: new ratios start after the next terminal pulse
    exp_train(1, 192, 230, 194, 5, "R6");
    exp_train(0, 201, 240, 201, 4, "R6");
    wr(2'd1, 5, 192);
    wr(2'd0, 4, 200);

    // R4: slow channel reprogrammed
    exp_train(4, 250, 330, 255, 30, "R4");
    exp_err(250, 330, 1'b0, "R4");
    wr(2'd2, 30, 250);

    // R5: out-of-range writes ignored
    exp_train(4, 340, 420, 345, 30, "R5");
    exp_train(0, 340, 420, 341, 4, "R5");
    exp_train(1, 340, 420, 344, 5, "R5");
    wr(2'd2, 81, 340);
    wr(2'd2, 23, 342);
    wr(2'd0, 0, 344);
    wr(2'd1, 65, 346);

    // R8: breach raises sticky flag
    exp_err(430, 431, 1'b0, "R8");
    exp_err(432, 451, 1'b1, "R8");
    exp_train(0, 431, 700, 433, 40, "R3");
    wr(2'd0, 40, 430);

    // R9: clear ignored while breach persists, zero write ignored
    exp_err(452, 482, 1'b1, "R9");
    exp_err(483, 500, 1'b0, "R9");
    wr(2'd3, 1, 452);
    wr(2'd2, 50, 462);
    wr(2'd3, 0, 472);
    wr(2'd3, 1, 482);

    // R4 upper boundary, R2 fixed trains later on
    exp_train(4, 502, 700, 515, 80, "R4");
    exp_train(2, 700, 900, 703, 64, "R2");
    exp_train(3, 700, 800, 701, 6, "R2");
    exp_train(5, 700, 800, 707, 12, "R2");
    exp_train(6, 700, 800, 701, 3, "R7");
    exp_train(7, 700, 800, 701, 6, "R2");
    wr(2'd2, 80, 502);

    // R4 lower boundary, R3 ratio 1 again
    exp_train(0, 713, 760, 713, 1, "R7");
    exp_train(4, 712, 850, 755, 24, "R4");
    exp_err(700, 850, 1'b0, "R8");
    wr(2'd0, 1, 710);
    wr(2'd2, 24, 712);

    while (cyc < 910) @(negedge clk);
    if (q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL R1 monitor: actual %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule